// File: doc/BRIEF.md
# Load-Balanced Token Matching Scheduler

This block is the scheduler of one middle port in a load-balanced switch with N ports. Packets wait in queues at their input ports. Only small request tokens reach this scheduler, each naming an input and an output. The tokens come from a fixed round-robin spreading pattern, so each middle port sees about one N-th of the arrivals. The block counts the tokens for each input-output pair and builds one matching per frame of N cycles. It then gives out that matching as grants, one input per slot. A grant tells an input port to release the packet at the head of its queue for the named output. Each queue is drained from its head only, so packets of a flow leave in arrival order and no reordering stage is needed.

Matching runs as an overlapped pipeline. While the grants of the current matching go out during a frame, the block also visits one input per slot. At each visit it adds that input's counter under two permutations to two running weights: the current matching, and a fresh candidate. The candidate maps input i to output i XOR k, where k comes from a free-running LFSR. At the frame boundary the heavier of the two becomes the next matching, and ties keep the current one. So a random draw can only improve the stored weight. Pairs whose counter is zero at the boundary are masked out of the next frame's grants.

Top module: `lbtok_sched`

## Requirements
- R1: While `rst_n` is low all counters and the stored matching are cleared and `gnt_vld` is 0. During the first frame after release, which is the first N cycles, no grant is issued.
- R2: With no tokens ever accepted, no grant is ever issued.
- R3: Slots count cycles since reset release, modulo N. A grant in slot s always carries `gnt_src` = s, so each input gets at most one grant per frame.
- R4: Within one frame no output index is granted twice.
- R5: A grant is issued only for a pair whose token count is nonzero. Each grant consumes exactly one token. Once arrivals stop, the total number of grants for a pair equals the number of tokens accepted for it.
- R6: A token and a grant for the same pair in the same cycle leave that pair's count unchanged. No token is lost and none is created.
- R7: A pair's count saturates at 2^CW-1. A token that arrives at the saturated value, with no grant for the same pair in that cycle, is dropped.
- R8: A candidate replaces the stored matching only if its weight is strictly larger, where weight is the sum of the counts of its pairs. When a single pair holds tokens and no other pair does, its grants come in consecutive frames, from the first one until the pair is empty.
- R9: Every matching is a permutation of the form output = input XOR k. All grants within one frame share the same value of `gnt_src` XOR `gnt_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tok_vld | input | 1 | A request token is present this cycle |
| tok_src | input | log2(N) | Input port index of the token |
| tok_dst | input | log2(N) | Output port index of the token |
| gnt_vld | output | 1 | A grant is issued this cycle |
| gnt_src | output | log2(N) | Input port that should release its head-of-line packet |
| gnt_dst | output | log2(N) | Output port of the granted packet |

## Verification
The bench builds the block with N=4 and CW=2. With these values a frame lasts four cycles and a counter saturates after three tokens. A short burst of six tokens therefore forces saturation even when grants drain the pair during the burst. The small key space means the LFSR soon draws the key that matches any given pair, so the single-flow, netting and mixed-traffic drains all finish within a few hundred cycles. The bench also times tokens to land in the slot where their pair is granted, which exercises the same-cycle netting of R6 across several frames in a row.

// File: rtl/lbtok_pkg.sv
package lbtok_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] v);
    lfsr_next = (v >> 1) ^ (v[0] ? LFSR_TAPS : '0);
  endfunction
endpackage

// File: rtl/lbtok_cnt_bank.sv
module lbtok_cnt_bank #(
  parameter int N  = 8,
  parameter int CW = 4,
  localparam int IW = $clog2(N),
  localparam int NC = N * N * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_vld,
  input  logic [IW-1:0] inc_src,
  input  logic [IW-1:0] inc_dst,
  input  logic          dec_vld,
  input  logic [IW-1:0] dec_src,
  input  logic [IW-1:0] dec_dst,
  output logic [NC-1:0] cnt_q_flat,
  output logic [NC-1:0] cnt_d_flat
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  for (genvar gi = 0; gi < N; gi++) begin : g_src
    for (genvar gj = 0; gj < N; gj++) begin : g_dst
      logic          hit_inc, hit_dec, en;
      logic [CW-1:0] q, d;

      assign hit_inc = inc_vld && (inc_src == IW'(gi)) && (inc_dst == IW'(gj));
      assign hit_dec = dec_vld && (dec_src == IW'(gi)) && (dec_dst == IW'(gj));
      assign en      = hit_inc ^ hit_dec;

      always_comb begin
        d = q;
        if (hit_inc && !hit_dec) begin
          if (q != CMAX) d = q + CW'(1);
        end else if (hit_dec && !hit_inc) begin
          d = q - CW'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
      end

      assign cnt_q_flat[(gi*N+gj)*CW +: CW] = q;
      assign cnt_d_flat[(gi*N+gj)*CW +: CW] = d;
    end
  end
endmodule

// File: rtl/lbtok_matcher.sv
module lbtok_matcher
  import lbtok_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = 4,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  localparam int IW = $clog2(N),
  localparam int WW = CW + IW,
  localparam int NC = N * N * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] cnt_q_flat,
  input  logic [NC-1:0] cnt_d_flat,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_src,
  output logic [IW-1:0] gnt_dst
);
  logic [IW-1:0]     slot_q, slot_d, cand_q, cand_d, key_q, key_d, sel_key;
  logic              mvld_q, mvld_d, sel_vld, take, frame_end;
  logic [N-1:0]      act_q, act_d;
  logic [WW-1:0]     wc_q, wc_d, wp_q, wp_d, wc_sum, wp_sum;
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [CW-1:0]     rd_cand, rd_cur;

  always_comb begin
    frame_end = (slot_q == IW'(N-1));
    rd_cand   = cnt_q_flat[int'({slot_q, slot_q ^ cand_q})*CW +: CW];
    rd_cur    = mvld_q ? cnt_q_flat[int'({slot_q, slot_q ^ key_q})*CW +: CW] : '0;
    wc_sum    = wc_q + WW'(rd_cand);
    wp_sum    = wp_q + WW'(rd_cur);
    take      = (wc_sum > wp_sum);
    sel_key   = take ? cand_q : key_q;
    sel_vld   = mvld_q | take;

    slot_d = slot_q + IW'(1);
    wc_d   = wc_sum;
    wp_d   = wp_sum;
    key_d  = key_q;
    mvld_d = mvld_q;
    act_d  = act_q;
    lfsr_d = lfsr_q;
    cand_d = cand_q;
    if (frame_end) begin
      wc_d   = '0;
      wp_d   = '0;
      key_d  = sel_key;
      mvld_d = sel_vld;
      lfsr_d = lfsr_next(lfsr_q);
      cand_d = lfsr_d[IW-1:0];
      for (int i = 0; i < N; i++) begin
        act_d[i] = sel_vld &&
          (cnt_d_flat[int'({IW'(i), IW'(i) ^ sel_key})*CW +: CW] != '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      wc_q   <= '0;
      wp_q   <= '0;
      key_q  <= '0;
      mvld_q <= 1'b0;
      act_q  <= '0;
      lfsr_q <= SEED;
      cand_q <= SEED[IW-1:0];
    end else begin
      slot_q <= slot_d;
      wc_q   <= wc_d;
      wp_q   <= wp_d;
      if (frame_end) begin
        key_q  <= key_d;
        mvld_q <= mvld_d;
        act_q  <= act_d;
        lfsr_q <= lfsr_d;
        cand_q <= cand_d;
      end
    end
  end

  assign gnt_vld = mvld_q & act_q[slot_q];
  assign gnt_src = slot_q;
  assign gnt_dst = slot_q ^ key_q;
endmodule

// File: rtl/lbtok_sched.sv
module lbtok_sched #(
  parameter int N  = 8,
  parameter int CW = 4,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_vld,
  input  logic [IW-1:0] tok_src,
  input  logic [IW-1:0] tok_dst,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_src,
  output logic [IW-1:0] gnt_dst
);
  localparam int NC = N * N * CW;

  logic [NC-1:0] cnt_q_flat, cnt_d_flat;

  lbtok_cnt_bank #(.N(N), .CW(CW)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .inc_vld(tok_vld), .inc_src(tok_src), .inc_dst(tok_dst),
    .dec_vld(gnt_vld), .dec_src(gnt_src), .dec_dst(gnt_dst),
    .cnt_q_flat(cnt_q_flat), .cnt_d_flat(cnt_d_flat)
  );

  lbtok_matcher #(.N(N), .CW(CW), .SEED(SEED)) match_i (
    .clk(clk), .rst_n(rst_n),
    .cnt_q_flat(cnt_q_flat), .cnt_d_flat(cnt_d_flat),
    .gnt_vld(gnt_vld), .gnt_src(gnt_src), .gnt_dst(gnt_dst)
  );
endmodule

// File: rtl/lbtok_sched_chk.sv
module lbtok_sched_chk #(
  parameter int N  = 8,
  parameter int CW = 4,
  localparam int IW = $clog2(N),
  localparam int NC = N * N * CW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tok_vld,
  input logic [IW-1:0] tok_src,
  input logic [IW-1:0] tok_dst,
  input logic          gnt_vld,
  input logic [IW-1:0] gnt_src,
  input logic [IW-1:0] gnt_dst,
  input logic [NC-1:0] cnt_q_flat
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [IW:0]     age_q;
  logic [IW-1:0]   ph_q;
  logic [N-1:0]    used_q;
  logic [2*IW-1:0] g_idx, t_idx, g_idx_q, t_idx_q;
  logic [CW-1:0]   g_val, t_val, g_exp_q, t_exp_q, g_now, t_now;
  logic            same, g_chk_q, n_chk_q, s_chk_q;

  assign g_idx = {gnt_src, gnt_dst};
  assign t_idx = {tok_src, tok_dst};
  assign g_val = cnt_q_flat[int'(g_idx)*CW +: CW];
  assign t_val = cnt_q_flat[int'(t_idx)*CW +: CW];
  assign g_now = cnt_q_flat[int'(g_idx_q)*CW +: CW];
  assign t_now = cnt_q_flat[int'(t_idx_q)*CW +: CW];
  assign same  = tok_vld && gnt_vld && (g_idx == t_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0; ph_q <= '0; used_q <= '0;
      g_chk_q <= 1'b0; n_chk_q <= 1'b0; s_chk_q <= 1'b0;
      g_idx_q <= '0; t_idx_q <= '0; g_exp_q <= '0; t_exp_q <= '0;
    end else begin
      if (age_q < (IW+1)'(N)) age_q <= age_q + (IW+1)'(1);
      ph_q    <= ph_q + IW'(1);
      used_q  <= (ph_q == IW'(N-1)) ? '0 :
                 (used_q | (gnt_vld ? (N'(1) << gnt_dst) : '0));
      g_chk_q <= gnt_vld && !same;
      n_chk_q <= same;
      s_chk_q <= tok_vld && (t_val == CMAX) && !same;
      g_idx_q <= g_idx;
      t_idx_q <= t_idx;
      g_exp_q <= g_val - CW'(1);
      t_exp_q <= t_val;
    end
  end

  // R1
  first_frame_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q < (IW+1)'(N)) |-> !gnt_vld);
  // R3
  grant_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> (gnt_src == ph_q));
  // R4
  out_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> !used_q[gnt_dst]);
  // R5
  grant_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> (g_val != '0));
  // R5
  grant_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g_chk_q |-> (g_now == g_exp_q));
  // R6
  net_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_chk_q |-> (t_now == t_exp_q));
  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_chk_q |-> (t_now == CMAX));
endmodule

bind lbtok_sched lbtok_sched_chk #(.N(N), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .tok_vld(tok_vld), .tok_src(tok_src), .tok_dst(tok_dst),
  .gnt_vld(gnt_vld), .gnt_src(gnt_src), .gnt_dst(gnt_dst),
  .cnt_q_flat(cnt_q_flat)
);

// File: tb/lbtok_sched_tb_top.sv
`timescale 1ns/1ps
module lbtok_sched_tb_top;
  localparam int N    = 4;
  localparam int CW   = 2;
  localparam int IW   = $clog2(N);
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tok_vld;
  logic [IW-1:0] tok_src, tok_dst;
  logic          gnt_vld;
  logic [IW-1:0] gnt_src, gnt_dst;

  int checks = 0;
  int failures = 0;
  int cnt_m [N][N];
  int g_tot [N][N];
  int acc_tot;
  int coin;
  int cyc;
  logic [N-1:0] used;
  int fkey;
  bit fkey_set;
  bit w_on, w_seen;
  int w_src, w_dst, w_last;
  event ev_wgnt;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lbtok_sched #(.N(N), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .tok_vld(tok_vld), .tok_src(tok_src), .tok_dst(tok_dst),
    .gnt_vld(gnt_vld), .gnt_src(gnt_src), .gnt_dst(gnt_dst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor and reference model, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0;
    end else begin
      int slot, fr;
      slot = cyc % N;
      fr   = cyc / N;
      if (slot == 0) begin used = '0; fkey_set = 1'b0; end
      if (gnt_vld) begin
        int s, d;
        s = int'(gnt_src); d = int'(gnt_dst);
        chk(fr > 0, "R1 first frame grant", fr, 1);
        chk(s == slot, "R3 grant src vs slot", s, slot);
        chk(!used[d], "R4 output reused in frame", d, -1);
        used[d] = 1'b1;
        if (fkey_set) chk((s ^ d) == fkey, "R9 frame key", s ^ d, fkey);
        else begin fkey = s ^ d; fkey_set = 1'b1; end
        chk(cnt_m[s][d] > 0, "R5 grant on empty pair", cnt_m[s][d], 1);
        g_tot[s][d]++;
        if (w_on && s == w_src && d == w_dst) begin
          if (w_seen) chk(fr == w_last + 1, "R8 consecutive frames", fr, w_last + 1);
          w_seen = 1'b1;
          w_last = fr;
          -> ev_wgnt;
        end
      end
      if (tok_vld && gnt_vld && tok_src == gnt_src && tok_dst == gnt_dst) begin
        coin++;
        acc_tot++;
      end else begin
        if (tok_vld) begin
          if (cnt_m[tok_src][tok_dst] < CMAX) begin
            cnt_m[tok_src][tok_dst]++;
            acc_tot++;
          end
        end
        if (gnt_vld && cnt_m[gnt_src][gnt_dst] > 0) cnt_m[gnt_src][gnt_dst]--;
      end
      cyc++;
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; tok_vld = 1'b0; tok_src = '0; tok_dst = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin cnt_m[i][j] = 0; g_tot[i][j] = 0; end
    acc_tot = 0; coin = 0; w_on = 0; w_seen = 0; w_last = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(gnt_vld == 1'b0, "R1 grant during reset", int'(gnt_vld), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic send(input int s, input int d, input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      tok_vld = 1'b1; tok_src = IW'(s); tok_dst = IW'(d);
      @(posedge clk); #1;
      tok_vld = 1'b0;
      repeat (gap) @(posedge clk);
    end
  endtask

  function automatic int model_sum();
    int t = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) t += cnt_m[i][j];
    return t;
  endfunction

  function automatic int grant_sum();
    int t = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) t += g_tot[i][j];
    return t;
  endfunction

  task automatic drain(input string req);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (model_sum() == 0) break;
    end
    #1;
    chk(model_sum() == 0, req, model_sum(), 0);
  endtask

  task automatic t_reset();
    do_reset();
    send(0, 0, 2, 0);
    drain("R1 tokens after reset drained");
    chk(g_tot[0][0] == 2, "R1 grants after reset", g_tot[0][0], 2);
  endtask

  task automatic t_idle();
    do_reset();
    repeat (400) @(posedge clk);
    #1;
    chk(grant_sum() == 0, "R2 idle grants", grant_sum(), 0);
  endtask

  task automatic t_single();
    do_reset();
    w_on = 1; w_src = 1; w_dst = 2;
    send(1, 2, 3, 1);
    drain("R5 single flow drained");
    chk(g_tot[1][2] == 3, "R5 single flow grants", g_tot[1][2], 3);
    chk(w_seen, "R8 single flow granted", int'(w_seen), 1);
    chk(grant_sum() == 3, "R5 no stray grants", grant_sum(), 3);
  endtask

  task automatic t_sat();
    do_reset();
    send(3, 0, 6, 0);
    drain("R7 saturated flow drained");
    chk(g_tot[3][0] == acc_tot, "R7 grants equal accepted", g_tot[3][0], acc_tot);
    chk(g_tot[3][0] < 6, "R7 tokens dropped at saturation", g_tot[3][0], 5);
  endtask

  task automatic t_net();
    do_reset();
    w_on = 1; w_src = 0; w_dst = 1;
    send(0, 1, 2, 0);
    @(ev_wgnt);
    repeat (N-1) @(posedge clk);
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      tok_vld = 1'b1; tok_src = IW'(0); tok_dst = IW'(1);
      @(posedge clk); #1;
      tok_vld = 1'b0;
      repeat (N-2) @(posedge clk);
    end
    drain("R6 netted flow drained");
    chk(coin == 6, "R6 same-cycle token and grant", coin, 6);
    chk(g_tot[0][1] == 8, "R6 grants equal tokens", g_tot[0][1], 8);
  endtask

  task automatic t_mix();
    do_reset();
    for (int k = 0; k < 24; k++) send(k % N, (k * 3 + 1) % N, 1, 2);
    drain("R5 mixed traffic drained");
    chk(grant_sum() == acc_tot, "R5 mixed grants equal accepted", grant_sum(), acc_tot);
    chk(acc_tot > 0, "R5 mixed tokens accepted", acc_tot, 24);
  endtask

  initial begin
    #950000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog R5 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tok_vld = 1'b0; tok_src = '0; tok_dst = '0;
    t_reset();
    t_idle();
    t_single();
    t_sat();
    t_net();
    t_mix();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule